// File: doc/BRIEF.md
# Lockable Station Address Register Bank

This block holds the six-byte station (MAC) address of a network port in byte-wide registers that a host writes one byte at a time. A command register at the offset just above the address bytes acts as a write lock. The host first puts the command mode field into the unlock value, then writes the address bytes, then returns the mode to normal. Address writes made while the bank is locked are dropped. Reads of every byte are always allowed.

When the host locks the bank again and at least one accepted byte write changed a stored value during that session, the bank raises a one-cycle change pulse for the management side. Changes are never reported byte by byte. While the bank is unlocked, a hold output tells the receive path to stop comparing frames against the address, so no frame is ever matched against a half-written value.

A three-state machine controls the lock. `ST_LOCKED` is the reset state and ignores address writes. A command write with mode 2'b11 takes it to `ST_OPEN`. In `ST_OPEN`, address writes are accepted. A command write with any other mode leaves `ST_OPEN`: it goes to `ST_NOTIFY` if the dirty flag is set, and to `ST_LOCKED` otherwise. `ST_NOTIFY` lasts exactly one cycle. It drives the pulse, clears the dirty flag and locks address writes. From `ST_NOTIFY` the machine goes to `ST_OPEN` if that same cycle carries an unlock command write, and to `ST_LOCKED` otherwise.

Top module: `station_addr_bank`

## Requirements
- R1: After reset, `station_addr` equals the `DEFAULT_ADDR` parameter, `match_hold` and `addr_changed` are 0, the bank is locked and the command readback is 8'h00.
- R2: The command register sits at offset 6, and its mode field is `wr_data[7:6]`. Mode 2'b11 unlocks address writes. Every other mode locks them. A read at offset 6 returns the last written mode in bits 7:6, with zeros below.
- R3: Address byte k (k = 0..5) sits at offset k and appears on `station_addr[8k+7:8k]`. A write to it while the bank is locked leaves the stored value unchanged.
- R4: A write to an address byte while the bank is unlocked is visible on `station_addr` and `rd_data` in the cycle after the write edge.
- R5: `rd_data` shows the byte at `addr` combinationally, whatever the lock state. Offset 7 reads 8'h00.
- R6: A locking command write that ends a session in which an accepted byte write changed a stored value makes `addr_changed` high for exactly the one cycle after that write edge.
- R7: A session in which no accepted write changed a stored value produces no pulse. This includes a session where a byte is rewritten with its current value.
- R8: `match_hold` is high from the cycle after an unlocking command write until the locking command write edge.
- R9: The pulse clears the change record, so an immediately following session with no change produces no pulse.
- R10: An address write in the pulse cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| addr | input | 3 | Byte offset for both reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| station_addr | output | 48 | Stored address, byte k at bits 8k+7:8k |
| addr_changed | output | 1 | One-cycle change notification |
| match_hold | output | 1 | Suspend address matching while unlocked |

## Verification
The bench covers the following corner cases:
- A write to a locked byte. A design without the lock would corrupt the address.
- An unlock attempt with mode 2'b01. A decoder that looks at only one mode bit would open the bank.
- Locking with mode 2'b10. A design that locks only on 2'b00 would stay open.
- Rewriting a byte with its current value. A design that marks dirty on every write would pulse spuriously.
- A byte write issued in the pulse cycle. A design that keeps the bank open one cycle too long would accept it.
- An empty session directly after a pulse. A design that never clears its change record would pulse again.

A behavioural model driven by random traffic then checks every output on every clock.

// File: rtl/sab_pkg.sv
package sab_pkg;
    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_OPEN   = 2'd1,
        ST_NOTIFY = 2'd2
    } sab_state_e;

    localparam logic [1:0] MODE_UNLOCK = 2'b11;
endpackage

// File: rtl/sab_lock_fsm.sv
module sab_lock_fsm
    import sab_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic [1:0] cmd_mode,
    input  logic       dirty,
    output logic       open,
    output logic       notify
);
    sab_state_e state_q, state_d;
    logic       unlock_req;

    assign unlock_req = cmd_wr && (cmd_mode == MODE_UNLOCK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (unlock_req) state_d = ST_OPEN;
            ST_OPEN: begin
                if (cmd_wr && !unlock_req) state_d = dirty ? ST_NOTIFY : ST_LOCKED;
            end
            ST_NOTIFY: state_d = unlock_req ? ST_OPEN : ST_LOCKED;
            default:   state_d = ST_LOCKED;
        endcase
    end

    always_comb begin
        open   = 1'b0;
        notify = 1'b0;
        unique case (state_q)
            ST_LOCKED: ;
            ST_OPEN:   open   = 1'b1;
            ST_NOTIFY: notify = 1'b1;
            default:   ;
        endcase
    end

    AST_NOTIFY_ONLY_FROM_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        notify |-> $past(open)); // R6
endmodule

// File: rtl/sab_addr_store.sv
module sab_addr_store #(
    parameter int          NBYTES       = 6,
    parameter logic [NBYTES*8-1:0] DEFAULT_ADDR = '0,
    localparam int         IW           = $clog2(NBYTES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_idx,
    input  logic [7:0]          wr_data,
    input  logic                open,
    input  logic                notify,
    output logic [NBYTES*8-1:0] bytes_flat,
    output logic                dirty
);
    logic [NBYTES-1:0] changed_vec;

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        logic       hit;
        logic [7:0] byte_q;

        assign hit            = wr_en && open && (wr_idx == IW'(i));
        assign changed_vec[i] = hit && (wr_data != byte_q);
        assign bytes_flat[i*8 +: 8] = byte_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   byte_q <= DEFAULT_ADDR[i*8 +: 8];
            else if (hit) byte_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              dirty <= 1'b0;
        else if (notify)         dirty <= 1'b0;
        else if (|changed_vec)   dirty <= 1'b1;
    end

    AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !open |=> $stable(bytes_flat)); // R3
    AST_DIRTY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        notify |=> !dirty); // R9
endmodule

// File: rtl/station_addr_bank.sv
module station_addr_bank
    import sab_pkg::*;
#(
    parameter int                  NBYTES       = 6,
    parameter logic [NBYTES*8-1:0] DEFAULT_ADDR = 48'h0A1B2C3D4E5F,
    localparam int                 AW           = $clog2(NBYTES + 1),
    localparam int                 CMD_OFS      = NBYTES
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       addr,
    input  logic [7:0]          wr_data,
    output logic [7:0]          rd_data,
    output logic [NBYTES*8-1:0] station_addr,
    output logic                addr_changed,
    output logic                match_hold
);
    logic       cmd_wr;
    logic       byte_wr;
    logic [1:0] mode_q;
    logic       open, notify, dirty;

    assign cmd_wr  = wr_en && (addr == AW'(CMD_OFS));
    assign byte_wr = wr_en && (addr <  AW'(NBYTES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mode_q <= 2'b00;
        else if (cmd_wr) mode_q <= wr_data[7:6];
    end

    sab_lock_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .cmd_mode (wr_data[7:6]),
        .dirty    (dirty),
        .open     (open),
        .notify   (notify)
    );

    sab_addr_store #(
        .NBYTES       (NBYTES),
        .DEFAULT_ADDR (DEFAULT_ADDR)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (byte_wr),
        .wr_idx     (addr),
        .wr_data    (wr_data),
        .open       (open),
        .notify     (notify),
        .bytes_flat (station_addr),
        .dirty      (dirty)
    );

    always_comb begin
        rd_data = 8'h00;
        if (addr < AW'(NBYTES))         rd_data = station_addr[addr*8 +: 8];
        else if (addr == AW'(CMD_OFS))  rd_data = {mode_q, 6'b0};
    end

    assign addr_changed = notify;
    assign match_hold   = open;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        addr_changed |=> !addr_changed); // R6
    AST_HOLD_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_hold) |-> $past(cmd_wr && wr_data[7:6] == MODE_UNLOCK)); // R8
    AST_PULSE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        addr_changed |-> $past(match_hold)); // R6
endmodule

// File: tb/station_addr_bank_tb_top.sv
module station_addr_bank_tb_top;
    localparam logic [47:0] DEF = 48'h0A1B2C3D4E5F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic [47:0] station_addr;
    logic        addr_changed, match_hold;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    station_addr_bank dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .station_addr(station_addr),
        .addr_changed(addr_changed), .match_hold(match_hold)
    );

    // behavioural reference
    logic [7:0] m_b [6];
    logic [1:0] m_mode;
    bit m_open, m_pulse, m_chg;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) m_b[i] = DEF[i*8 +: 8];
            m_mode = 0; m_open = 0; m_pulse = 0; m_chg = 0;
        end else begin
            bit np;
            np = 0;
            if (wr_en && addr < 6 && m_open) begin
                if (m_b[addr] != wr_data) m_chg = 1;
                m_b[addr] = wr_data;
            end
            if (wr_en && addr == 6) begin
                m_mode = wr_data[7:6];
                if (wr_data[7:6] == 2'b11) m_open = 1;
                else if (m_open) begin
                    np = m_chg; m_chg = 0; m_open = 0;
                end
            end
            m_pulse = np;
        end
    end

    function automatic logic [47:0] m_flat();
        logic [47:0] f;
        for (int i = 0; i < 6; i++) f[i*8 +: 8] = m_b[i];
        return f;
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] er;
            er = (addr < 6) ? m_b[addr] : (addr == 6) ? {m_mode, 6'b0} : 8'h00;
            chk(station_addr, m_flat(), "R4 model address");
            chk(addr_changed, m_pulse, "R6 model pulse");
            chk(match_hold, m_open, "R8 model hold");
            chk(rd_data, er, "R5 model read");
        end
    end

    task automatic cyc(input logic w, input logic [2:0] a, input logic [7:0] d);
        wr_en = w; addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        addr = a; #1;
        chk(rd_data, e, tag);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        chk(station_addr, DEF, "R1 reset address");
        chk(addr_changed, 0, "R1 reset pulse");
        chk(match_hold, 0, "R1 reset hold");
        rd(3'd6, 8'h00, "R1 reset cmd readback");

        cyc(1, 3'd0, 8'hAA);
        chk(station_addr, DEF, "R3 locked write ignored");
        cyc(1, 3'd6, 8'h40);
        chk(match_hold, 0, "R2 mode 01 keeps lock");
        rd(3'd6, 8'h40, "R2 cmd readback");
        cyc(1, 3'd0, 8'hAB);
        chk(station_addr[7:0], 8'h5F, "R2 mode 01 write ignored");

        cyc(1, 3'd6, 8'hC0);
        chk(match_hold, 1, "R8 hold after unlock");
        cyc(1, 3'd0, 8'h11);
        chk(station_addr[7:0], 8'h11, "R4 unlocked write");
        cyc(1, 3'd1, 8'h4E);
        cyc(1, 3'd6, 8'h00);
        chk(addr_changed, 1, "R6 pulse on lock");
        chk(match_hold, 0, "R8 hold drops");
        cyc(1, 3'd2, 8'h77);
        chk(addr_changed, 0, "R6 pulse one cycle");
        chk(station_addr[23:16], 8'h3D, "R10 write in pulse cycle");

        cyc(1, 3'd6, 8'hC0);
        cyc(1, 3'd0, 8'h11);
        cyc(1, 3'd6, 8'h00);
        chk(addr_changed, 0, "R7 same-value session");

        cyc(1, 3'd6, 8'hC0);
        cyc(1, 3'd5, 8'h99);
        cyc(1, 3'd6, 8'h80);
        chk(addr_changed, 1, "R6 mode 10 locks with pulse");
        cyc(0, 3'd0, 8'h00);
        cyc(1, 3'd6, 8'hC0);
        cyc(1, 3'd6, 8'h00);
        chk(addr_changed, 0, "R9 record cleared");

        rd(3'd0, 8'h11, "R5 read locked byte");
        rd(3'd5, 8'h99, "R5 read top byte");
        rd(3'd7, 8'h00, "R5 offset 7");

        for (int n = 0; n < 3000; n++) begin
            logic [2:0] a;
            logic [7:0] d;
            a = 3'($urandom_range(0, 7));
            d = 8'($urandom_range(0, 3));
            if (a == 6) d = {2'($urandom_range(0, 3)), 6'd0};
            cyc(1'($urandom_range(0, 1)), a, d);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule